// File: doc/BRIEF.md
# SPI Chip-Select Controller

This block produces up to eight chip-select lines for an SPI master from one programmed select word. Software writes the word through a simple write port and can read it back. The word holds one enable bit per line, an ownership bit and a polarity bit.

When the ownership bit is set, software drives the lines directly. When it is clear, the lines follow the transfer engine's active flag: a line asserts only while a transfer runs and its bit is set. The polarity bit flips every output after the ownership multiplexer, so the same word can serve active-low and active-high peripherals. Without inversion an asserted line is driven low. With inversion it is driven high.

Top module: `spi_csel_top`

## Requirements
- R1: After reset the register reads 0 and every chip-select output is high.
- R2: One cycle after a write, the read port returns bits [9:0] of the written word, and all higher read bits are zero. Bits [7:0] are the line enables, bit 8 is direct ownership and bit 9 is output inversion.
- R3: While no write is strobed, the register and the read value stay unchanged, whatever the transfer-active input does.
- R4: With bit 8 set and bit 9 clear, each output is low exactly when its enable bit is set, independent of the transfer-active input.
- R5: With bit 8 clear and bit 9 clear, each output is low exactly when the transfer-active input is high and its enable bit is set; otherwise it is high.
- R6: With bit 9 set, each output is the complement of the value R4 or R5 gives for the same state, in both modes.
- R7: A read-modify-write that changes one enable bit changes only that output and leaves the other lines as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the select register |
| wrData | input | DATA_W | Write data; only bits [9:0] are kept |
| rdData | output | DATA_W | Current register contents, zero-extended |
| xferActive | input | 1 | High while the SPI engine is moving a transfer |
| selN | output | NUM_SEL | Chip-select outputs |

## Verification
Two functions can fall in the same cycle: a register write that changes ownership or polarity, and a toggle of the transfer-active input. The bench changes the transfer-active input on the same edge as a write that switches the mode. It then judges the outputs against a model of the new register value combined with the new transfer-active level. It also checks that the lines do not hold a mixture of the old and new state.

// File: rtl/spi_csel_pkg.sv
package spi_csel_pkg;
  localparam int MAX_SEL = 8;
  localparam int DIRECT_BIT = 8;
  localparam int INVERT_BIT = 9;
  localparam int REG_W = 10;

  typedef struct packed {
    logic                load;
    logic [MAX_SEL-1:0]  enables;
    logic                direct;
    logic                invert;
  } selCmd_t;
endpackage

// File: rtl/spi_csel_ctrl.sv
module spi_csel_ctrl
  import spi_csel_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output selCmd_t           cmd
);
  always_comb begin
    cmd.load    = wrEn;
    cmd.enables = wrData[MAX_SEL-1:0];
    cmd.direct  = wrData[DIRECT_BIT];
    cmd.invert  = wrData[INVERT_BIT];
  end
endmodule

// File: rtl/spi_csel_dp.sv
module spi_csel_dp
  import spi_csel_pkg::*;
#(
  parameter int NUM_SEL = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  selCmd_t            cmd,
  input  logic               xferActive,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SEL-1:0] selN
);
  logic [MAX_SEL-1:0] enReg;
  logic               directReg;
  logic               invertReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= '0;
      directReg <= 1'b0;
      invertReg <= 1'b0;
    end else if (cmd.load) begin
      enReg     <= cmd.enables;
      directReg <= cmd.direct;
      invertReg <= cmd.invert;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[MAX_SEL-1:0] = enReg;
    rdData[DIRECT_BIT]  = directReg;
    rdData[INVERT_BIT]  = invertReg;
  end

  for (genvar i = 0; i < NUM_SEL; i++) begin : gLine
    logic asserted;
    assign asserted = enReg[i] & (directReg | xferActive);
    assign selN[i]  = invertReg ? asserted : ~asserted;
  end
endmodule

// File: rtl/spi_csel_top.sv
module spi_csel_top
  import spi_csel_pkg::*;
#(
  parameter int NUM_SEL = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               xferActive,
  output logic [NUM_SEL-1:0] selN
);
  selCmd_t cmd;

  spi_csel_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .wrEn(wrEn), .wrData(wrData), .cmd(cmd)
  );

  spi_csel_dp #(.NUM_SEL(NUM_SEL), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .xferActive(xferActive),
    .rdData(rdData), .selN(selN)
  );
endmodule

// File: rtl/spi_csel_checker.sv
module spi_csel_checker #(
  parameter int NUM_SEL = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic               xferActive,
  input logic [NUM_SEL-1:0] selN
);
  logic [DATA_W-1:0] keptBits;
  always_comb begin
    keptBits = '0;
    keptBits[9:0] = wrData[9:0];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (rdData == '0)); // R1

  AST_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == $past(keptBits))); // R2

  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData)); // R3

  AST_DIRECT_LINES: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[8] && !rdData[9]) |-> (selN == ~rdData[NUM_SEL-1:0])); // R4

  AST_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[8] && !rdData[9] && !xferActive) |-> (selN == {NUM_SEL{1'b1}})); // R5

  AST_INVERT_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[8] && rdData[9]) |-> (selN == rdData[NUM_SEL-1:0])); // R6
endmodule

bind spi_csel_top spi_csel_checker #(.NUM_SEL(NUM_SEL), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .xferActive(xferActive), .selN(selN)
);

// File: tb/tb_spi_csel_top.sv
`timescale 1ns/1ps
module tb_spi_csel_top;
  localparam int NUM_SEL = 8;
  localparam int DATA_W  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic xferActive = 1'b0;
  logic [NUM_SEL-1:0] selN;

  int checks = 0;
  int errors = 0;
  logic [9:0] model = '0;

  always #2.5 clk = ~clk;

  spi_csel_top #(.NUM_SEL(NUM_SEL), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .xferActive(xferActive), .selN(selN)
  );

  function automatic logic [NUM_SEL-1:0] expSel(logic [9:0] r, logic act);
    logic [NUM_SEL-1:0] a;
    a = r[NUM_SEL-1:0] & {NUM_SEL{r[8] | act}};
    return r[9] ? a : ~a;
  endfunction

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [DATA_W-1:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    model = v[9:0];
  endtask

  task automatic checkAll(string req);
    chk(req, rdData, {22'd0, model});
    chk(req, {24'd0, selN}, {24'd0, expSel(model, xferActive)});
  endtask

  task automatic testReset();
    chk("R1", rdData, '0);
    chk("R1", {24'd0, selN}, 32'h0000_00ff);
  endtask

  task automatic testReadback();
    writeReg(32'hFFFF_F3A5);
    chk("R2", rdData, 32'h0000_03A5);
    writeReg(32'h0000_015A);
    chk("R2", rdData, 32'h0000_015A);
  endtask

  task automatic testHold();
    writeReg(32'h0000_0033);
    @(negedge clk); xferActive = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3", rdData, 32'h0000_0033);
    xferActive = 1'b0;
    @(negedge clk);
    chk("R3", rdData, 32'h0000_0033);
  endtask

  task automatic testDirect();
    writeReg(32'h0000_0181);
    xferActive = 1'b0; #1;
    chk("R4", {24'd0, selN}, 32'h0000_007e);
    xferActive = 1'b1; #1;
    chk("R4", {24'd0, selN}, 32'h0000_007e);
    xferActive = 1'b0;
  endtask

  task automatic testAuto();
    writeReg(32'h0000_0024);
    xferActive = 1'b0; #1;
    chk("R5", {24'd0, selN}, 32'h0000_00ff);
    xferActive = 1'b1; #1;
    chk("R5", {24'd0, selN}, 32'h0000_00db);
    xferActive = 1'b0; #1;
    chk("R5", {24'd0, selN}, 32'h0000_00ff);
  endtask

  task automatic testInvert();
    writeReg(32'h0000_0303);
    chk("R6", {24'd0, selN}, 32'h0000_0003);
    writeReg(32'h0000_0210);
    xferActive = 1'b0; #1;
    chk("R6", {24'd0, selN}, 32'h0000_0000);
    xferActive = 1'b1; #1;
    chk("R6", {24'd0, selN}, 32'h0000_0010);
    xferActive = 1'b0;
  endtask

  task automatic testRmw();
    logic [DATA_W-1:0] v;
    writeReg(32'h0000_0149);
    v = rdData;
    v[2] = 1'b1;
    writeReg(v);
    chk("R7", {24'd0, selN}, 32'h0000_00b2);
    v = rdData;
    v[0] = 1'b0;
    writeReg(v);
    chk("R7", {24'd0, selN}, 32'h0000_00b3);
  endtask

  task automatic testCollide();
    writeReg(32'h0000_00f0);
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h0000_000f; xferActive = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; model = 10'h00f;
    checkAll("R5");
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h0000_030f; xferActive = 1'b0;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; model = 10'h30f;
    checkAll("R6");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testHold();
    testDirect();
    testAuto();
    testInvert();
    testRmw();
    testCollide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule